// File: doc/BRIEF.md
# Flash Status Register with Sticky Errors

This block keeps the eight-bit status word of a flash write engine and serves it to the host bus. The engine reports through two eight-bit masks, one that raises bits and one that drops them. Readiness sits in bit 7. The error flags sit in bits 1, 3, 4 and 5:
- bit 1: an operation was aborted on a locked block.
- bit 3: the programming supply was out of range.
- bit 4: a program operation failed.
- bit 5: erase failure.

Bits 2 and 6 are engine-controlled state flags. Bit 0 is always zero.

The error flags are sticky. Once raised, they survive any number of later operations, so one read after a batch shows whether any step in it went wrong. Only a dedicated clear strobe, which the command decoder gives on the clear-status command, or a reset drops them.

Reads go through a small two-state machine. In state `RD_IDLE`, chip-enable or output-enable is high and the output is zero. The transition `IDLE->HELD` is taken at the first clock edge where both enables are sampled low. At that edge the current status value is captured, and the machine enters `RD_HELD`, where it presents that snapshot in the low byte with the upper byte at zero. The transition `HELD->IDLE` is taken when either enable is sampled high. A newer value therefore appears only after an enable toggles.

Top module: `flash_status_reg`

## Requirements
- R1: Reset (rst_n low) loads the status register with 0x80, meaning ready with no errors. The first status read after reset returns 0x0080.
- R2: A one in eng_set raises the matching status bit for bits 7 down to 1. eng_set[0] has no effect, and bit 0 always reads 0.
- R3: A one in eng_clr drops the matching bit only for bits 2, 6 and 7. eng_clr ones at bits 1, 3, 4 and 5 have no effect.
- R4: If eng_set and eng_clr name the same bit in one cycle, the bit ends up set.
- R5: A clr_cmd pulse drops bits 1, 3, 4 and 5. It leaves bits 2, 6 and 7 as they were.
- R6: If clr_cmd and an eng_set error bit come in the same cycle, that error bit ends up set.
- R7: Error bits raised by successive operations accumulate as a bitwise OR until a clr_cmd or a reset.
- R8: At the first clock edge where ce_n and oe_n are both sampled low, the block captures the status value held just before that edge. From the cycle after that edge, rd_data shows {8'h00, snapshot}.
- R9: While ce_n and oe_n both stay low, rd_data does not change, whatever happens to the status register.
- R10: When ce_n or oe_n is sampled high, rd_data is 0 from the next cycle. Lowering both again takes a fresh snapshot.
- R11: rd_data[15:8] is 0x00 during every status read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_set | input | 8 | Engine bit-raise mask (bit 0 has no effect) |
| eng_clr | input | 8 | Engine bit-drop mask (honoured for bits 2, 6, 7) |
| clr_cmd | input | 1 | One-cycle clear-status strobe from the command decoder |
| ce_n | input | 1 | Chip enable, active low, synchronous to clk |
| oe_n | input | 1 | Output enable, active low, synchronous to clk |
| rd_data | output | 16 | Status read data: {8'h00, snapshot} while held, otherwise 0 |

## Verification
Two functions can fall in the same cycle, and both are covered.

The first is a clear-status strobe arriving together with a fresh engine error. The bench issues clr_cmd and eng_set with bit 4 in one step, then reads the register, and expects bit 4 to remain while the other error bits are gone. 

The second is a snapshot edge that coincides with a register update. The bench lowers both enables in the same step that raises a new bit. It expects the held read to show the older value, and it expects the new bit to appear only after an enable toggles.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int unsigned STAT_W = 8;

    // bit roles inside the status word
    localparam logic [STAT_W-1:0] ERR_MASK   = 8'h3A; // bits 5,4,3,1 sticky
    localparam logic [STAT_W-1:0] ENG_CLR_OK = 8'hC4; // bits 7,6,2 engine-clearable
    localparam logic [STAT_W-1:0] ENG_SET_OK = 8'hFE; // bits 7..1 engine-settable
    localparam logic [STAT_W-1:0] RESET_VAL  = 8'h80; // ready, no errors

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/fsr_bits.sv
module fsr_bits
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] eng_set,
    input  logic [STAT_W-1:0] eng_clr,
    input  logic              clr_cmd,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] drop_mask;
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        drop_mask = (eng_clr & ENG_CLR_OK) | (clr_cmd ? ERR_MASK : '0);
        stat_d    = (stat_q & ~drop_mask) | (eng_set & ENG_SET_OK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= RESET_VAL;
        else        stat_q <= stat_d;
    end

    // R7
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((stat_q & $past(stat_q) & ERR_MASK) == ($past(stat_q) & ERR_MASK)));

    // R5
    clear_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && ((eng_set & ERR_MASK) == '0)) |=> ((stat_q & ERR_MASK) == '0));
endmodule

// File: rtl/fsr_read_fsm.sv
module fsr_read_fsm
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [STAT_W-1:0] stat_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned PAD_W = DATA_W - STAT_W;

    rd_state_e         st_q, st_d;
    logic [STAT_W-1:0] snap_q;
    logic              sel;

    assign sel = !ce_n && !oe_n;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (sel)  st_d = RD_HELD;   // IDLE->HELD
            RD_HELD: if (!sel) st_d = RD_IDLE;   // HELD->IDLE
            default: st_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RD_IDLE;
            snap_q <= RESET_VAL;
        end else begin
            st_q <= st_d;
            if (st_q == RD_IDLE && st_d == RD_HELD) snap_q <= stat_q;
        end
    end

    always_comb begin
        unique case (st_q)
            RD_HELD: rd_data = {{PAD_W{1'b0}}, snap_q};
            default: rd_data = '0;
        endcase
    end

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_HELD && sel) |=> $stable(rd_data));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (rd_data == '0));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] eng_set,
    input  logic [STAT_W-1:0] eng_clr,
    input  logic              clr_cmd,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data
);
    logic [STAT_W-1:0] stat_q;

    fsr_bits u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .eng_set (eng_set),
        .eng_clr (eng_clr),
        .clr_cmd (clr_cmd),
        .stat_q  (stat_q)
    );

    fsr_read_fsm #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .stat_q  (stat_q),
        .rd_data (rd_data)
    );

    // R2
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_set[7] |=> stat_q[7]);

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(!ce_n && !oe_n) |=> (rd_data[DATA_W-1:STAT_W] == '0));
endmodule

// File: tb/sim_flash_status_reg.sv
`timescale 1ns/1ps
module sim_flash_status_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  eng_set, eng_clr;
    logic        clr_cmd, ce_n, oe_n;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    // reference state
    logic [7:0] m_stat;
    logic [7:0] m_snap;
    bit         m_held;

    always #4 clk = ~clk;   // 125 MHz

    flash_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .eng_set(eng_set), .eng_clr(eng_clr),
        .clr_cmd(clr_cmd), .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data)
    );

    task automatic m_reset();
        m_stat = 8'h80;
        m_snap = 8'h80;
        m_held = 0;
    endtask

    task automatic step(input logic [7:0] s, input logic [7:0] c, input logic cmd,
                        input logic ce, input logic oe, input string tag);
        logic [7:0] drop;
        @(negedge clk);
        eng_set = s; eng_clr = c; clr_cmd = cmd; ce_n = ce; oe_n = oe;
        @(posedge clk);
        #1;
        if (!ce && !oe) begin
            if (!m_held) begin m_held = 1; m_snap = m_stat; end
        end else m_held = 0;
        drop   = (c & 8'hC4) | (cmd ? 8'h3A : 8'h00);
        m_stat = (m_stat & ~drop) | (s & 8'hFE);
        exp_q.push_back(m_held ? {8'h00, m_snap} : 16'h0000);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 0; eng_set = 0; eng_clr = 0; clr_cmd = 0; ce_n = 1; oe_n = 1;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        step(8'h00, 8'h00, 0, 1, 1, "R10 idle after reset");
        step(8'h00, 8'h00, 0, 0, 0, "R1 reset value read");
        step(8'h00, 8'h00, 0, 0, 0, "R11 upper byte zero");
        step(8'h00, 8'h00, 0, 1, 0, "R10 deselect");
        // start operation: busy
        step(8'h00, 8'h80, 0, 1, 1, "R3 engine drops ready");
        step(8'h18, 8'h00, 0, 1, 1, "R2 engine raises errors");
        step(8'h00, 8'h3A, 0, 1, 1, "R3 engine clear on error bits");
        step(8'h00, 8'h00, 0, 0, 0, "R3 error bits kept");
        step(8'h02, 8'h00, 0, 0, 0, "R9 held while bit1 set");
        step(8'h80, 8'h00, 0, 0, 0, "R9 held while ready set");
        step(8'h00, 8'h00, 0, 0, 1, "R10 oe high");
        step(8'h00, 8'h00, 0, 0, 0, "R7 accumulated errors");
        step(8'h00, 8'h00, 0, 1, 0, "R10 ce high");
        // snapshot edge coincides with update
        step(8'h20, 8'h00, 0, 0, 0, "R8 pre-edge snapshot");
        step(8'h00, 8'h00, 0, 0, 1, "R10 toggle");
        step(8'h00, 8'h00, 0, 0, 0, "R8 fresh snapshot");
        // clear command keeps bits 2,6,7
        step(8'h44, 8'h00, 0, 1, 1, "R2 raise state flags");
        step(8'h00, 8'h00, 1, 1, 1, "R5 clear command");
        step(8'h00, 8'h00, 0, 0, 0, "R5 only errors cleared");
        // clear command and new error together
        step(8'h1A, 8'h00, 0, 1, 1, "R7 new errors");
        step(8'h10, 8'h00, 1, 1, 1, "R6 clear with set");
        step(8'h00, 8'h00, 0, 0, 0, "R6 set wins over clear");
        // engine set and clear on same bit
        step(8'h04, 8'h04, 0, 1, 1, "R4 set and clear same bit");
        step(8'h00, 8'h00, 0, 0, 0, "R4 set wins");
        step(8'h00, 8'hC4, 0, 1, 1, "R3 engine clears 7,6,2");
        step(8'h00, 8'h00, 0, 0, 0, "R3 engine clear result");
        step(8'h01, 8'h00, 0, 1, 1, "R2 bit0 ignored");
        step(8'h00, 8'h00, 0, 0, 0, "R2 bit0 stays zero");
        // reset mid run
        @(negedge clk); rst_n = 0; ce_n = 1; oe_n = 1; eng_set = 0; eng_clr = 0; clr_cmd = 0;
        m_reset();
        @(negedge clk); rst_n = 1;
        step(8'h00, 8'h00, 0, 0, 0, "R1 reset clears errors");
        step(8'h00, 8'h00, 0, 1, 1, "R10 final idle");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule